// File: doc/BRIEF.md
# Multiprecision Reconfigurable Multiplier Array

This block multiplies unsigned operands at one of three precisions on a single shared grid of 8x8 sub-multipliers. A two-bit mode input picks how the grid is grouped. It can act as nine independent byte multipliers, as three independent 16x16 multipliers, or as one 32x32 multiplier. Operands arrive packed into two 72-bit words. Products leave packed into one 144-bit word, with a valid flag for each lane.

Each sub-multiplier forms its product with radix-4 Booth digits. A 16x16 lane adds four sub-products, shifted by 0, 8, 8 and 16 bits. The 32x32 result adds four such 16-bit quadrant products, shifted by 0, 16, 16 and 32 bits. The output stage is registered, so the result appears one clock after its operands are sampled.

Top module: `mp_mult_array`

## Requirements
- R1: With mode 2'b00, lane k (k = 0..8) yields opA[8k+7:8k] * opB[8k+7:8k] in product[16k+15:16k].
- R2: With mode 2'b01, lane L (L = 0..2) yields opA[16L+15:16L] * opB[16L+15:16L] in product[32L+31:32L].
- R3: With mode 2'b10, product[63:0] equals opA[31:0] * opB[31:0].
- R4: All operands are unsigned. All-ones operands give the largest product for the lane width, for example 8'hFF * 8'hFF = 16'hFE01.
- R5: The result is registered. The product and valid flags for operands sampled at one rising edge appear just after that edge, and they do not change between edges.
- R6: laneValid[k] marks an active lane. When inValid is high, laneValid is 9'h1FF in mode 2'b00, 9'h007 in mode 2'b01 and 9'h001 in mode 2'b10. When inValid is low, laneValid is 9'h000.
- R7: Product bits of lanes that the current mode does not use read zero. Operand bits that lie outside the active lanes have no effect on the product.
- R8: Mode 2'b11 is reserved. It gives a zero product and all valid flags low.
- R9: While rstN is low, product and laneValid are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands on opA/opB are valid this cycle |
| mode | input | 2 | Precision select: 00 byte, 01 half, 10 word, 11 reserved |
| opA | input | 72 | Packed first operands |
| opB | input | 72 | Packed second operands |
| product | output | 144 | Packed registered products |
| laneValid | output | 9 | Registered per-lane valid flags |

## Verification
Some properties are checked on every cycle. These are the full 32x32 result and the lowest byte lane against a reference multiply. They also cover the zero upper field in the 16x16 and 32x32 modes, the silent reserved mode, and the low flags when inValid is low. Only the bench's scenarios show the rest. That covers each lane of every mode against the reference under table and random operands, and the all-ones corners. It also covers the one-cycle latency seen between edges, and that garbage in the unused operand bits leaves the packed result unchanged.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
  localparam int SUB_W   = 8;
  localparam int LANES_N = 9;
  localparam int LANES_M = 3;
  localparam int GRID    = 4;
  localparam int SUBS    = GRID * GRID;
  localparam int QUADS   = 4;
  localparam int OPW     = LANES_N * SUB_W;
  localparam int PRODW   = 2 * OPW;
  localparam int MIDW    = 2 * SUB_W;
  localparam int WIDEW   = 4 * SUB_W;

  typedef enum logic [1:0] {
    MODE_8   = 2'b00,
    MODE_16  = 2'b01,
    MODE_32  = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef struct packed {
    logic               use8;
    logic               use16;
    logic               use32;
    logic [LANES_N-1:0] laneMask;
  } ctrl_t;
endpackage

// File: rtl/mpm_sub8.sv
module mpm_sub8 #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int ND = W / 2 + 1;
  localparam int EW = 2 * W + 4;

  logic [2*ND:0]        bx;
  logic signed [EW-1:0] aExt;
  logic signed [EW-1:0] acc;
  logic signed [EW-1:0] term;

  assign bx   = {{(2*ND-W){1'b0}}, b, 1'b0};
  assign aExt = signed'({{(EW-W){1'b0}}, a});

  always_comb begin
    acc  = '0;
    term = '0;
    for (int k = 0; k < ND; k++) begin
      unique case (bx[2*k +: 3])
        3'b001, 3'b010: term = aExt;
        3'b011:         term = aExt <<< 1;
        3'b100:         term = -(aExt <<< 1);
        3'b101, 3'b110: term = -aExt;
        default:        term = '0;
      endcase
      acc = acc + (term <<< (2 * k));
    end
    p = acc[2*W-1:0];
  end
endmodule

// File: rtl/mpm_ctrl.sv
module mpm_ctrl
  import mpm_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       inValid,
  output ctrl_t      ctrlS
);
  localparam logic [LANES_N-1:0] MASK_8  = {LANES_N{1'b1}};
  localparam logic [LANES_N-1:0] MASK_16 = LANES_N'((1 << LANES_M) - 1);
  localparam logic [LANES_N-1:0] MASK_32 = LANES_N'(1);

  always_comb begin
    ctrlS = '0;
    unique case (mode_e'(mode))
      MODE_8: begin
        ctrlS.use8     = 1'b1;
        ctrlS.laneMask = inValid ? MASK_8 : '0;
      end
      MODE_16: begin
        ctrlS.use16    = 1'b1;
        ctrlS.laneMask = inValid ? MASK_16 : '0;
      end
      MODE_32: begin
        ctrlS.use32    = 1'b1;
        ctrlS.laneMask = inValid ? MASK_32 : '0;
      end
      default: ctrlS = '0;
    endcase
  end
endmodule

// File: rtl/mpm_datapath.sv
module mpm_datapath
  import mpm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrlS,
  input  logic [OPW-1:0]     opA,
  input  logic [OPW-1:0]     opB,
  output logic [PRODW-1:0]   product,
  output logic [LANES_N-1:0] laneValid
);
  logic [SUB_W-1:0] subA [SUBS];
  logic [SUB_W-1:0] subB [SUBS];
  logic [MIDW-1:0]  subP [SUBS];
  logic [WIDEW-1:0] quad [QUADS];
  logic [2*WIDEW-1:0] wide;
  logic [PRODW-1:0] prodNext;

  // Operand routing: sub (i,j) multiplies A byte row i by B byte column j
  always_comb begin
    for (int s = 0; s < SUBS; s++) begin
      int i;
      int j;
      int lane;
      i = s / GRID;
      j = s % GRID;
      lane = ((i / 2) == (j / 2)) ? (i / 2) : (((i / 2) == 0) ? 2 : -1);
      subA[s] = '0;
      subB[s] = '0;
      if (ctrlS.use8 && s < LANES_N) begin
        subA[s] = opA[SUB_W*s +: SUB_W];
        subB[s] = opB[SUB_W*s +: SUB_W];
      end else if (ctrlS.use16 && lane >= 0) begin
        subA[s] = opA[MIDW*lane + SUB_W*(i%2) +: SUB_W];
        subB[s] = opB[MIDW*lane + SUB_W*(j%2) +: SUB_W];
      end else if (ctrlS.use32) begin
        subA[s] = opA[SUB_W*i +: SUB_W];
        subB[s] = opB[SUB_W*j +: SUB_W];
      end
    end
  end

  for (genvar g = 0; g < SUBS; g++) begin : gSub
    mpm_sub8 #(.W(SUB_W)) u_sub (.a(subA[g]), .b(subB[g]), .p(subP[g]));
  end

  // Quadrant q = 2p + r combines four byte products into a 16x16 product
  always_comb begin
    for (int q = 0; q < QUADS; q++) begin
      int i0;
      int j0;
      i0 = 2 * (q / 2);
      j0 = 2 * (q % 2);
      quad[q] = {{MIDW{1'b0}}, subP[i0*GRID + j0]}
              + ({{MIDW{1'b0}}, subP[(i0+1)*GRID + j0]} << SUB_W)
              + ({{MIDW{1'b0}}, subP[i0*GRID + j0 + 1]} << SUB_W)
              + ({{MIDW{1'b0}}, subP[(i0+1)*GRID + j0 + 1]} << MIDW);
    end
    wide = {{WIDEW{1'b0}}, quad[0]}
         + ({{WIDEW{1'b0}}, quad[1]} << MIDW)
         + ({{WIDEW{1'b0}}, quad[2]} << MIDW)
         + ({{WIDEW{1'b0}}, quad[3]} << WIDEW);
  end

  // Lane packing of the next product word
  always_comb begin
    prodNext = '0;
    if (ctrlS.use8) begin
      for (int k = 0; k < LANES_N; k++) prodNext[MIDW*k +: MIDW] = subP[k];
    end else if (ctrlS.use16) begin
      prodNext[0 +: WIDEW]       = quad[0];
      prodNext[WIDEW +: WIDEW]   = quad[3];
      prodNext[2*WIDEW +: WIDEW] = quad[1];
    end else if (ctrlS.use32) begin
      prodNext[0 +: 2*WIDEW] = wide;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      product   <= '0;
      laneValid <= '0;
    end else begin
      product   <= prodNext;
      laneValid <= ctrlS.laneMask;
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlS.use8, ctrlS.use16, ctrlS.use32})); // R8
  AST_WIDE_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.use32 |=> product[2*WIDEW-1:0] ==
      (64'($past(opA[WIDEW-1:0])) * 64'($past(opB[WIDEW-1:0])))); // R3
  AST_BYTE_LANE0: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.use8 |=> product[MIDW-1:0] ==
      (16'($past(opA[SUB_W-1:0])) * 16'($past(opB[SUB_W-1:0])))); // R1
  AST_MID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.use16 |=> product[PRODW-1:LANES_M*WIDEW] == '0); // R7
  AST_WIDE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.use32 |=> product[PRODW-1:2*WIDEW] == '0); // R7
endmodule

// File: rtl/mp_mult_array.sv
module mp_mult_array
  import mpm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [1:0]         mode,
  input  logic [OPW-1:0]     opA,
  input  logic [OPW-1:0]     opB,
  output logic [PRODW-1:0]   product,
  output logic [LANES_N-1:0] laneValid
);
  ctrl_t ctrlS;

  mpm_ctrl u_ctrl (.mode(mode), .inValid(inValid), .ctrlS(ctrlS));

  mpm_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrlS(ctrlS), .opA(opA), .opB(opB),
    .product(product), .laneValid(laneValid)
  );

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11) |=> (product == '0 && laneValid == '0)); // R8
  AST_IDLE_NOVALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> laneValid == '0); // R6
endmodule

// File: tb/mp_mult_array_tb.sv
module mp_mult_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [1:0]  V_MODE [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b00};
  localparam logic [71:0] V_A [NV] = '{
    72'h0102030405060708FF, 72'hFFFFFFFFFFFFFFFFFF, 72'h5A5A5AABCD12349876,
    72'hFFFFFFFFFFFFFFFFFF, 72'hC3C3C3C3C3DEADBEEF, 72'h0000000000FFFFFFFF,
    72'h123456789ABCDEF012, 72'h000000000000000000};
  localparam logic [71:0] V_B [NV] = '{
    72'h0908070605040302FF, 72'hFFFFFFFFFFFFFFFFFF, 72'hA5A5A5FFFF00015432,
    72'hFFFFFFFFFFFFFFFFFF, 72'h3C3C3C3C3CCAFEF00D, 72'h0000000000FFFFFFFF,
    72'hFEDCBA987654321012, 72'h7F7F7F7F7F7F7F7F7F};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [71:0] opA = '0;
  logic [71:0] opB = '0;
  logic [143:0] product;
  logic [8:0] laneValid;
  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_mult_array u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .opA(opA), .opB(opB), .product(product), .laneValid(laneValid));

  function automatic logic [143:0] refProd(logic [1:0] m, logic [71:0] a, logic [71:0] b);
    logic [143:0] r;
    r = '0;
    case (m)
      2'b00: for (int k = 0; k < 9; k++) r[16*k +: 16] = 16'(a[8*k +: 8]) * 16'(b[8*k +: 8]);
      2'b01: for (int l = 0; l < 3; l++) r[32*l +: 32] = 32'(a[16*l +: 16]) * 32'(b[16*l +: 16]);
      2'b10: r[63:0] = 64'(a[31:0]) * 64'(b[31:0]);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [8:0] refValid(logic [1:0] m, logic v);
    if (!v) return 9'h000;
    case (m)
      2'b00: return 9'h1FF;
      2'b01: return 9'h007;
      2'b10: return 9'h001;
      default: return 9'h000;
    endcase
  endfunction

  function automatic string modeTag(logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [143:0] act, logic [143:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic applyAndCheck(logic [1:0] m, logic [71:0] a, logic [71:0] b, string extra);
    @(negedge clk);
    mode = m; opA = a; opB = b; inValid = 1'b1;
    @(posedge clk);
    #1;
    check({modeTag(m), extra}, product, refProd(m, a, b));
    check("R6 laneValid", 144'(laneValid), 144'(refValid(m, 1'b1)));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [143:0] held;
    logic [143:0] first;
    // R9 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R9 product", product, '0);
    check("R9 laneValid", 144'(laneValid), '0);
    @(negedge clk);
    rstN = 1'b1;

    // Vector table, R4 all-ones and R7 garbage upper bits included
    for (int v = 0; v < NV; v++) applyAndCheck(V_MODE[v], V_A[v], V_B[v], " table R4 R7");

    // Random operands in each mode
    for (int m = 0; m < 3; m++) begin
      for (int n = 0; n < 12; n++) begin
        logic [95:0] ra;
        logic [95:0] rb;
        ra = {$urandom(), $urandom(), $urandom()};
        rb = {$urandom(), $urandom(), $urandom()};
        applyAndCheck(2'(m), ra[71:0], rb[71:0], " random");
      end
    end

    // R7: unused operand bits have no effect in mode 01
    applyAndCheck(2'b01, 72'h000000123456789ABC, 72'h0000000F0F0E0D0C0B, " R7 base");
    first = product;
    applyAndCheck(2'b01, 72'hFFFFFF123456789ABC, 72'hA5A5A50F0F0E0D0C0B, " R7 dirty");
    check("R7 upper bits ignored", product, first);

    // R5: output holds between edges, new value after the edge
    applyAndCheck(2'b10, 72'h0000000000FFFF0001, 72'h000000000000000003, " R5 first");
    held = product;
    @(negedge clk);
    opA = 72'h000000000012345678; opB = 72'h000000000087654321;
    #1;
    check("R5 hold before edge", product, held);
    @(posedge clk);
    #1;
    check("R5 update after edge", product, refProd(2'b10, opA, opB));

    // R6: inValid low clears the flags
    @(negedge clk);
    inValid = 1'b0; mode = 2'b00;
    @(posedge clk);
    #1;
    check("R6 idle laneValid", 144'(laneValid), '0);

    // R8: reserved mode with valid input
    @(negedge clk);
    inValid = 1'b1; mode = 2'b11; opA = '1; opB = '1;
    @(posedge clk);
    #1;
    check("R8 product", product, '0);
    check("R8 laneValid", 144'(laneValid), '0);

    // R9: reset asserted mid-run
    @(negedge clk);
    mode = 2'b00;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R9 async product", product, '0);
    check("R9 async laneValid", 144'(laneValid), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule